// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It takes a fast input clock and produces one single-cycle pulse for every N input cycles. The pulse goes to the phase comparator. N is not held in one long modulo counter. A small prescaler divides by either P or P+1. A coarse counter (B) counts prescaler periods, and a swallow counter (A) sets how many of those periods use the longer modulus. Together they give N = P×B + A.

A fixed-divide mode sets the prescaler to 1 and ignores the swallow count, so the ratio is simply B. A synchronous restart input reloads the counters from the configuration present at that edge. A combinational flag reports settings that break the rules on B and A. Configuration changes made without a restart are picked up only at the boundary between two output periods, so no output period is ever cut short or stretched.

Top module: `pll_fb_divider`

## Requirements
- R1: In dual-modulus mode (`fixed_mode`=0) the output pulses exactly once every P×B + A input cycles.
- R2: `psel` codes 0, 1, 2, 3 and 4 select P = 2, 4, 8, 16 and 32. Codes 5 to 7 are illegal in dual-modulus mode.
- R3: Within each output period, the first A prescaler periods last P+1 cycles and the remaining B−A periods last P cycles.
- R4: In dual-modulus mode, `cfg_invalid` is high whenever B = 0, B = 2, A ≥ B, or `psel` > 4. This flag follows the inputs in the same cycle.
- R5: In fixed mode (`fixed_mode`=1) the period is B cycles and A has no effect. B = 1 drives `div_out` high on every cycle. In this mode `cfg_invalid` is high only for B = 0.
- R6: When `sync` is sampled high, `div_out` is low at the next output update and the counters reload from the current inputs. The first pulse follows N edges after that sync edge.
- R7: Each output pulse is one input cycle wide whenever N ≥ 2.
- R8: Changes to `psel`, `a_val`, `b_val` or `fixed_mode` made without `sync` do not alter the period in progress. They take effect from the next period.
- R9: While `rst_n` is low, `div_out` is 0. The first edge after release loads the configuration without a pulse, and the first pulse follows N edges after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Synchronous restart of the counters |
| fixed_mode | input | 1 | 1 = prescaler bypassed, divide by B |
| psel | input | 3 | Prescaler modulus code (P = 2 << psel) |
| a_val | input | 6 | Swallow count A |
| b_val | input | 13 | Coarse count B |
| div_out | output | 1 | One-cycle pulse per output period |
| cfg_invalid | output | 1 | Current inputs form an illegal setting |

## Verification
The hardest case to reach from the ports is a configuration change that arrives in the middle of a period. The divider must finish that period with the old P, A and B and only then switch. To reach it, the stimulus starts a run, waits until the scoreboard shows that the second period is under way, and then changes the inputs a few cycles later without `sync`. It expects one more old-length interval followed by new-length ones. A second hard case is a `sync` issued deep inside a long period. That period's expected entry is flushed, and the next pulse must come exactly N edges after the sync edge.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

   // prescaler modulus for a select code: 2, 4, 8, 16, 32 ...
   function automatic int unsigned p_value(input logic [2:0] sel);
      return 32'd2 << sel;
   endfunction

   typedef struct packed {
      logic       fixed;
      logic [2:0] psel;
   } div_mode_t;

endpackage

// File: rtl/fbdiv_cfg_check.sv
module fbdiv_cfg_check #(
   parameter int A_W      = 6,
   parameter int B_W      = 13,
   parameter int PSEL_MAX = 4
) (
   input  logic           fixed_mode,
   input  logic [2:0]     psel,
   input  logic [A_W-1:0] a_val,
   input  logic [B_W-1:0] b_val,
   output logic           bad
);
   logic b_zero, b_two, a_ge_b, p_bad;

   always_comb begin
      b_zero = (b_val == '0);
      b_two  = (b_val == B_W'(2));
      a_ge_b = (B_W'(a_val) >= b_val);
      p_bad  = (psel > 3'(PSEL_MAX));
      if (fixed_mode) bad = b_zero;
      else            bad = b_zero | b_two | a_ge_b | p_bad;
   end
endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler #(
   parameter int PSEL_MAX = 4,
   parameter int PC_W     = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            mode_fixed,
   input  logic [2:0]      mode_psel,
   input  logic            swl_nxt,
   output logic            pre_end,
   output logic [PC_W-1:0] pc
);
   logic [2:0]      ps_c;
   logic [PC_W-1:0] rel;

   always_comb begin
      ps_c = (mode_psel > 3'(PSEL_MAX)) ? 3'(PSEL_MAX) : mode_psel;
      if (mode_fixed) rel = '0;
      else            rel = PC_W'(fbdiv_pkg::p_value(ps_c) - 32'd1 + 32'(swl_nxt));
   end

   assign pre_end = (pc == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pc <= '0;
      else if (load || pre_end)   pc <= rel;
      else                        pc <= pc - 1'b1;
   end
endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow #(
   parameter int A_W = 6,
   parameter int B_W = 13
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           pre_end,
   input  logic           fixed_in,
   input  logic [A_W-1:0] a_in,
   input  logic [B_W-1:0] b_in,
   output logic           last_b,
   output logic           swl_nxt
);
   logic [A_W-1:0] a_cnt;
   logic [B_W-1:0] b_cnt;

   assign last_b  = (b_cnt <= B_W'(1));
   assign swl_nxt = load ? (!fixed_in && a_in != '0) : (a_cnt > A_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_cnt <= '0;
         b_cnt <= '0;
      end else if (load) begin
         b_cnt <= b_in;
         a_cnt <= fixed_in ? '0 : a_in;
      end else if (pre_end) begin
         b_cnt <= b_cnt - 1'b1;
         if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
      end
   end
endmodule

// File: rtl/pll_fb_divider.sv
module pll_fb_divider #(
   parameter int A_W      = 6,
   parameter int B_W      = 13,
   parameter int PSEL_MAX = 4,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sync,
   input  logic           fixed_mode,
   input  logic [2:0]     psel,
   input  logic [A_W-1:0] a_val,
   input  logic [B_W-1:0] b_val,
   output logic           div_out,
   output logic           cfg_invalid
);
   import fbdiv_pkg::*;

   localparam int P_MAX = 2 << PSEL_MAX;
   localparam int PC_W  = $clog2(P_MAX + 1);

   if (A_W > B_W)     begin : g_bad_aw   $error("A_W must not exceed B_W");   end
   if (PSEL_MAX > 6)  begin : g_bad_psel $error("PSEL_MAX out of range");     end
   if (B_W < 2)       begin : g_bad_bw   $error("B_W must be at least 2");    end

   div_mode_t       mode_act, mode_in, mode_use;
   logic            armed, load, terminal, pre_end, last_b, swl_nxt, pulse;
   logic [PC_W-1:0] pc;

   assign mode_in  = '{fixed: fixed_mode, psel: psel};
   assign terminal = pre_end & last_b;
   assign load     = sync | terminal | ~armed;
   assign mode_use = load ? mode_in : mode_act;
   assign pulse    = terminal & armed & ~sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         mode_act <= '0;
      end else begin
         armed <= 1'b1;
         if (load) mode_act <= mode_in;
      end
   end

   fbdiv_prescaler #(.PSEL_MAX(PSEL_MAX), .PC_W(PC_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .load(load),
      .mode_fixed(mode_use.fixed), .mode_psel(mode_use.psel),
      .swl_nxt(swl_nxt), .pre_end(pre_end), .pc(pc));

   fbdiv_swallow #(.A_W(A_W), .B_W(B_W)) u_swl (
      .clk(clk), .rst_n(rst_n), .load(load), .pre_end(pre_end),
      .fixed_in(fixed_mode), .a_in(a_val), .b_in(b_val),
      .last_b(last_b), .swl_nxt(swl_nxt));

   fbdiv_cfg_check #(.A_W(A_W), .B_W(B_W), .PSEL_MAX(PSEL_MAX)) u_cfg (
      .fixed_mode(fixed_mode), .psel(psel), .a_val(a_val), .b_val(b_val),
      .bad(cfg_invalid));

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) div_out <= 1'b0;
         else        div_out <= pulse;
      end
   end else begin : g_out_comb
      assign div_out = pulse & rst_n;
   end
endmodule

// File: rtl/fbdiv_checker.sv
module fbdiv_checker #(
   parameter int A_W      = 6,
   parameter int B_W      = 13,
   parameter int PC_W     = 6,
   parameter bit OUT_REG  = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sync,
   input logic            fixed_mode,
   input logic [A_W-1:0]  a_val,
   input logic [B_W-1:0]  b_val,
   input logic            cfg_invalid,
   input logic            div_out,
   input logic            load,
   input logic            pre_end,
   input logic            last_b,
   input logic            swl_nxt,
   input logic [PC_W-1:0] pc,
   input logic [3:0]      mode_bits
);
   logic       act_fixed;
   logic [2:0] act_psel;
   assign act_fixed = mode_bits[3];
   assign act_psel  = mode_bits[2:0];

   if (OUT_REG) begin : g_reg
      p_sync_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         sync |=> !div_out);
      p_pulse_at_b_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
         div_out |-> $past(pre_end && last_b));
   end else begin : g_comb
      p_sync_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         sync |-> !div_out);
      p_pulse_at_b_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
         div_out |-> (pre_end && last_b));
   end

   // R3: a swallowed prescaler period reloads with count P (modulus P+1)
   p_swallow_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_end && !load && swl_nxt && !act_fixed && act_psel <= 3'd4)
      |=> (pc == PC_W'(fbdiv_pkg::p_value(act_psel))));

   // R8: active mode only moves at a load
   p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(mode_bits));

   // R4: A not below B in dual mode is flagged
   p_invalid_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!fixed_mode && B_W'(a_val) >= b_val) |-> cfg_invalid);

   // R5: fixed mode never swallows
   p_fixed_no_swallow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_fixed && !load) |-> !swl_nxt);
endmodule

bind pll_fb_divider fbdiv_checker #(
   .A_W(A_W), .B_W(B_W), .PC_W(PC_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sync(sync), .fixed_mode(fixed_mode),
   .a_val(a_val), .b_val(b_val), .cfg_invalid(cfg_invalid),
   .div_out(div_out), .load(load), .pre_end(pre_end), .last_b(last_b),
   .swl_nxt(swl_nxt), .pc(pc), .mode_bits(mode_act)
);

// File: tb/pll_fb_divider_test.sv
module pll_fb_divider_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync = 1'b0;
   logic        fixed_mode = 1'b0;
   logic [2:0]  psel = '0;
   logic [5:0]  a_val = '0;
   logic [12:0] b_val = '0;
   logic        div_out, cfg_invalid;

   int    checks = 0;
   int    errors = 0;
   int    exp_q[$];
   string tag_q[$];
   int    cnt = 0;
   bit    rst_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_fb_divider uut (
      .clk(clk), .rst_n(rst_n), .sync(sync), .fixed_mode(fixed_mode),
      .psel(psel), .a_val(a_val), .b_val(b_val),
      .div_out(div_out), .cfg_invalid(cfg_invalid));

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int n_of(input bit fx, input int ps, input int a, input int b);
      if (fx) return b;
      return (2 << ps) * b + a;
   endfunction

   // monitor: interval since restart or last pulse, compared with the scoreboard
   always @(posedge clk) begin
      #1;
      if (!rst_n) rst_prev = 1'b0;
      else begin
         if (sync || !rst_prev) begin
            cnt = 0;
            check(div_out == 1'b0, sync ? "R6 output low after sync" : "R9 no pulse on first edge",
                  int'(div_out), 0);
         end else begin
            cnt++;
            if (div_out) begin
               if (exp_q.size() == 0) check(1'b0, "R7 unexpected pulse", cnt, 0);
               else begin
                  automatic int    e = exp_q.pop_front();
                  automatic string t = tag_q.pop_front();
                  check(cnt == e, t, cnt, e);
               end
               cnt = 0;
            end
         end
         rst_prev = 1'b1;
      end
   end

   task automatic push(input int n, input int times, input string t);
      for (int i = 0; i < times; i++) begin
         exp_q.push_back(n);
         tag_q.push_back(t);
      end
   endtask

   task automatic set_cfg(input bit fx, input int ps, input int a, input int b);
      fixed_mode = fx; psel = 3'(ps); a_val = 6'(a); b_val = 13'(b);
   endtask

   task automatic restart(input bit fx, input int ps, input int a, input int b,
                          input int times, input string t);
      @(negedge clk);
      set_cfg(fx, ps, a, b);
      sync = 1'b1;
      exp_q.delete(); tag_q.delete();
      push(n_of(fx, ps, a, b), times, t);
      @(negedge clk);
      sync = 1'b0;
   endtask

   task automatic wait_left(input int k);
      while (exp_q.size() > k) @(negedge clk);
   endtask

   task automatic chk_inv(input bit fx, input int ps, input int a, input int b,
                          input bit expv, input string t);
      @(negedge clk);
      set_cfg(fx, ps, a, b);
      #1;
      check(cfg_invalid == expv, t, int'(cfg_invalid), int'(expv));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(div_out == 1'b0, "R9 reset output", int'(div_out), 0);
      chk_inv(0, 0, 0, 2,    1, "R4 B=2 invalid");
      chk_inv(0, 0, 0, 0,    1, "R4 B=0 invalid");
      chk_inv(0, 1, 5, 5,    1, "R4 A=B invalid");
      chk_inv(0, 1, 7, 5,    1, "R4 A>B invalid");
      chk_inv(0, 5, 0, 3,    1, "R2 psel 5 invalid");
      chk_inv(0, 0, 2, 3,    0, "R4 B=3 A=2 legal");
      chk_inv(0, 2, 0, 1,    0, "R4 B=1 A=0 legal");
      chk_inv(0, 4, 63, 8191, 0, "R2 psel 4 max counts legal");
      chk_inv(1, 0, 9, 2,    0, "R5 fixed B=2 A ignored");
      chk_inv(1, 0, 0, 0,    1, "R5 fixed B=0 invalid");

      // R9: run from reset release, no sync
      @(negedge clk);
      set_cfg(0, 0, 2, 3);
      push(8, 3, "R9 period after reset");
      rst_n = 1'b1;
      wait_left(0);

      restart(0, 1, 3, 5, 3, "R1 P=4 B=5 A=3");
      wait_left(0);
      restart(0, 3, 0, 3, 2, "R2 P=16 B=3 A=0");
      wait_left(0);
      restart(0, 2, 0, 1, 3, "R1 P=8 B=1");
      wait_left(0);
      restart(0, 4, 3, 4, 2, "R3 P=32 B=4 A=3");
      wait_left(0);
      restart(0, 0, 0, 1, 4, "R7 N=2 pulse width");
      wait_left(0);
      restart(1, 0, 5, 280, 2, "R5 fixed B=280");
      wait_left(0);
      restart(1, 0, 0, 1, 6, "R5 fixed B=1");
      wait_left(2);

      // R8: change mid-period without sync
      restart(0, 1, 3, 5, 2, "R8 old period kept");
      wait_left(1);
      repeat (3) @(negedge clk);
      set_cfg(0, 0, 5, 6);
      push(17, 2, "R8 new period");
      wait_left(0);

      // R6: sync deep inside a long period
      restart(0, 4, 3, 4, 1, "R6 flushed");
      repeat (40) @(negedge clk);
      restart(0, 1, 0, 3, 2, "R6 period after sync");
      wait_left(0);

      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule